// File: doc/BRIEF.md
# Modulo Loop Branch Controller

This block resolves the closing branch of a software-pipelined counted loop. Before the loop starts, software writes two counts: the number of kernel iterations still to start (the loop count) and the number of extra passes needed to drain the pipeline (the drain count). Each time the loop-closing branch is presented, the controller picks one of three outcomes.

- **Kernel pass:** while the loop count is nonzero, it decrements that count and feeds a 1 into the first stage predicate.
- **Drain pass:** once the loop count is zero but the drain count is not, it decrements the drain count and feeds a 0 into the first stage predicate. The older stages keep running and the pipeline empties.
- **Exit:** when both counts are zero, the branch falls through.

Every kernel or drain pass is a taken branch. On each taken branch the stage predicates shift one place, and the controller tells the register file to rotate. The controller also keeps a rotation base, which moves down by one on each rotation, so a rename stage can map logical registers to physical ones.

All decisions are registered. A request sampled at one rising edge produces its taken, fall-through and rotate pulses, and its new counts, predicates and base, all visible in the following cycle.

Top module: `mloop_branch_ctrl`

## Requirements
- R1: After synchronous reset the loop count, drain count, every stage predicate and the rotation base are zero, and the taken, rotate and fall-through outputs are low.
- R2: A branch request with a nonzero loop count decrements the loop count by one, shifts a 1 into stage predicate bit 0, and leaves the drain count unchanged.
- R3: A branch request with a zero loop count and a nonzero drain count decrements the drain count by one, shifts a 0 into stage predicate bit 0, and leaves the loop count at zero.
- R4: A branch request with both counts zero raises the fall-through output for one cycle, keeps taken and rotate low, and changes neither the counts, the predicates nor the rotation base.
- R5: On every rotation, stage predicate bit k takes the previous value of bit k-1 for k from 1 to N_STAGES-1; without a rotation the predicates hold.
- R6: Taken and rotate are high together, for exactly one cycle per accepted kernel or drain request, in the cycle after the request edge; each rotation lowers the rotation base by one, modulo 2^ROT_W. Taken and fall-through are never high together.
- R7: A count write loads both counts from the write data. When it coincides with a branch request, the write wins and the request is ignored: no taken, rotate or fall-through pulse, and predicates and rotation base unchanged.
- R8: A cycle with neither a request nor a write changes no state and raises no output pulse.
- R9: Starting from loop count L and drain count E, consecutive requests give exactly L+E taken branches and then one fall-through. For L=4 and E=3 the rotation base ends 7 below its starting value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Load both counts this cycle |
| lc_wr_data | input | LC_W | Loop count value to load |
| ec_wr_data | input | EC_W | Drain count value to load |
| br_req | input | 1 | Loop-closing branch presented this cycle |
| br_taken | output | 1 | Previous request was taken |
| br_fall | output | 1 | Previous request fell through |
| rot_pulse | output | 1 | Register rotation strobe, one cycle |
| stage_pred | output | N_STAGES | Stage predicates, bit 0 guards the first stage |
| lc_q | output | LC_W | Current loop count |
| ec_q | output | EC_W | Current drain count |
| rot_base | output | ROT_W | Rotation base, two's complement |

## Verification
The bound checker examines every cycle against a single request or write:
- the decrement of the right count together with the bit fed into stage 0;
- the one-place predicate shift;
- the lock-step of taken and rotate, with the base stepping down;
- write priority;
- quiet cycles leaving state untouched.

Only the bench's scenarios show whole-loop behaviour. It sweeps every combination of starting counts in a small range, with and without idle gaps, and checks that the count of taken branches equals the sum of the counts. It checks that the predicate pattern fills and then drains exactly as the arithmetic model predicts, and that the base ends the stated distance from where it started. It also covers the maximum loop count.

// File: rtl/mlb_pkg.sv
`timescale 1ns/1ps
package mlb_pkg;

    // Outcome of one cycle of the branch controller
    typedef enum logic [1:0] {
        BR_NONE   = 2'd0,
        BR_KERNEL = 2'd1,
        BR_DRAIN  = 2'd2,
        BR_EXIT   = 2'd3
    } br_kind_e;

    typedef struct packed {
        br_kind_e kind;
        logic     fill_bit;  // value entering stage predicate 0
        logic     rotate;    // shift predicates and step the base
        logic     load;      // count write this cycle
    } br_step_t;

    function automatic br_step_t classify(input logic req, input logic wr,
                                          input logic lc_nz, input logic ec_nz);
        br_step_t s;
        s.kind     = BR_NONE;
        s.fill_bit = 1'b0;
        s.rotate   = 1'b0;
        s.load     = wr;
        if (!wr && req) begin
            if (lc_nz) begin
                s.kind     = BR_KERNEL;
                s.fill_bit = 1'b1;
                s.rotate   = 1'b1;
            end else if (ec_nz) begin
                s.kind     = BR_DRAIN;
                s.rotate   = 1'b1;
            end else begin
                s.kind     = BR_EXIT;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/mlb_decide.sv
`timescale 1ns/1ps
module mlb_decide
    import mlb_pkg::*;
#(
    parameter int LC_W = 8,
    parameter int EC_W = 4
) (
    input  logic            req,
    input  logic            wr,
    input  logic [LC_W-1:0] lc_q,
    input  logic [EC_W-1:0] ec_q,
    output br_step_t        step
);
    always_comb begin
        step = classify(req, wr, |lc_q, |ec_q);
    end
endmodule

// File: rtl/mlb_counters.sv
`timescale 1ns/1ps
module mlb_counters
    import mlb_pkg::*;
#(
    parameter int LC_W = 8,
    parameter int EC_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  br_step_t        step,
    input  logic [LC_W-1:0] lc_d,
    input  logic [EC_W-1:0] ec_d,
    output logic [LC_W-1:0] lc_q,
    output logic [EC_W-1:0] ec_q
);
    localparam logic [LC_W-1:0] LC_ONE = LC_W'(1);
    localparam logic [EC_W-1:0] EC_ONE = EC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            lc_q <= '0;
            ec_q <= '0;
        end else if (step.load) begin
            lc_q <= lc_d;
            ec_q <= ec_d;
        end else begin
            case (step.kind)
                BR_KERNEL: lc_q <= lc_q - LC_ONE;
                BR_DRAIN:  ec_q <= ec_q - EC_ONE;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mlb_pred_chain.sv
`timescale 1ns/1ps
module mlb_pred_chain #(
    parameter int N_STAGES = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                fill_bit,
    output logic [N_STAGES-1:0] pred
);
    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        logic nxt;
        if (g == 0) begin : g_head
            assign nxt = fill_bit;
        end else begin : g_tail
            assign nxt = pred[g-1];
        end
        always_ff @(posedge clk) begin
            if (rst)           pred[g] <= 1'b0;
            else if (shift_en) pred[g] <= nxt;
        end
    end
endmodule

// File: rtl/mlb_rotator.sv
`timescale 1ns/1ps
module mlb_rotator #(
    parameter int ROT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rotate,
    output logic             rot_pulse,
    output logic [ROT_W-1:0] rot_base
);
    localparam logic [ROT_W-1:0] BASE_STEP = ROT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rot_pulse <= 1'b0;
            rot_base  <= '0;
        end else begin
            rot_pulse <= rotate;
            if (rotate) rot_base <= rot_base - BASE_STEP;
        end
    end
endmodule

// File: rtl/mloop_branch_ctrl.sv
`timescale 1ns/1ps
module mloop_branch_ctrl
    import mlb_pkg::*;
#(
    parameter int LC_W     = 8,
    parameter int EC_W     = 4,
    parameter int N_STAGES = 3,
    parameter int ROT_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_wr_en,
    input  logic [LC_W-1:0]     lc_wr_data,
    input  logic [EC_W-1:0]     ec_wr_data,
    input  logic                br_req,
    output logic                br_taken,
    output logic                br_fall,
    output logic                rot_pulse,
    output logic [N_STAGES-1:0] stage_pred,
    output logic [LC_W-1:0]     lc_q,
    output logic [EC_W-1:0]     ec_q,
    output logic [ROT_W-1:0]    rot_base
);
    br_step_t step;

    mlb_decide #(.LC_W(LC_W), .EC_W(EC_W)) u_decide (
        .req (br_req),
        .wr  (cnt_wr_en),
        .lc_q(lc_q),
        .ec_q(ec_q),
        .step(step)
    );

    mlb_counters #(.LC_W(LC_W), .EC_W(EC_W)) u_counters (
        .clk (clk),
        .rst (rst),
        .step(step),
        .lc_d(lc_wr_data),
        .ec_d(ec_wr_data),
        .lc_q(lc_q),
        .ec_q(ec_q)
    );

    mlb_pred_chain #(.N_STAGES(N_STAGES)) u_preds (
        .clk     (clk),
        .rst     (rst),
        .shift_en(step.rotate),
        .fill_bit(step.fill_bit),
        .pred    (stage_pred)
    );

    mlb_rotator #(.ROT_W(ROT_W)) u_rot (
        .clk      (clk),
        .rst      (rst),
        .rotate   (step.rotate),
        .rot_pulse(rot_pulse),
        .rot_base (rot_base)
    );

    // Branch outcome flags, kept apart from the rotation strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            br_taken <= 1'b0;
            br_fall  <= 1'b0;
        end else begin
            br_taken <= (step.kind == BR_KERNEL) || (step.kind == BR_DRAIN);
            br_fall  <= (step.kind == BR_EXIT);
        end
    end
endmodule

// File: rtl/mloop_branch_chk.sv
`timescale 1ns/1ps
module mloop_branch_chk #(
    parameter int LC_W     = 8,
    parameter int EC_W     = 4,
    parameter int N_STAGES = 3,
    parameter int ROT_W    = 7
) (
    input logic                clk,
    input logic                rst,
    input logic                cnt_wr_en,
    input logic [LC_W-1:0]     lc_wr_data,
    input logic [EC_W-1:0]     ec_wr_data,
    input logic                br_req,
    input logic                br_taken,
    input logic                br_fall,
    input logic                rot_pulse,
    input logic [N_STAGES-1:0] stage_pred,
    input logic [LC_W-1:0]     lc_q,
    input logic [EC_W-1:0]     ec_q,
    input logic [ROT_W-1:0]    rot_base
);
    // R2
    kernel_step_chk: assert property (@(posedge clk) disable iff (rst)
        (br_req && !cnt_wr_en && lc_q != '0) |=>
            (lc_q == $past(lc_q) - LC_W'(1)) && $stable(ec_q) && br_taken && stage_pred[0]);

    // R3
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (br_req && !cnt_wr_en && lc_q == '0 && ec_q != '0) |=>
            (ec_q == $past(ec_q) - EC_W'(1)) && lc_q == '0 && br_taken && !stage_pred[0]);

    // R4
    exit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (br_req && !cnt_wr_en && lc_q == '0 && ec_q == '0) |=>
            br_fall && !br_taken && !rot_pulse && $stable(stage_pred) && $stable(rot_base) && ec_q == '0);

    // R5
    pred_shift_chk: assert property (@(posedge clk) disable iff (rst)
        rot_pulse |-> stage_pred[N_STAGES-1:1] == $past(stage_pred[N_STAGES-2:0]));

    // R6
    rot_with_taken_chk: assert property (@(posedge clk) disable iff (rst)
        rot_pulse == br_taken);

    // R6
    taken_fall_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({br_taken, br_fall}));

    // R6
    base_step_chk: assert property (@(posedge clk) disable iff (rst)
        rot_pulse |-> rot_base == $past(rot_base) - ROT_W'(1));

    // R7
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr_en |=> lc_q == $past(lc_wr_data) && ec_q == $past(ec_wr_data)
                      && !br_taken && !br_fall && !rot_pulse && $stable(stage_pred));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!br_req && !cnt_wr_en) |=> $stable(lc_q) && $stable(ec_q) && $stable(stage_pred)
                                    && $stable(rot_base) && !br_taken && !br_fall);
endmodule

bind mloop_branch_ctrl mloop_branch_chk #(
    .LC_W(LC_W), .EC_W(EC_W), .N_STAGES(N_STAGES), .ROT_W(ROT_W)
) i_chk (
    .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .lc_wr_data(lc_wr_data),
    .ec_wr_data(ec_wr_data), .br_req(br_req), .br_taken(br_taken), .br_fall(br_fall),
    .rot_pulse(rot_pulse), .stage_pred(stage_pred), .lc_q(lc_q), .ec_q(ec_q),
    .rot_base(rot_base)
);

// File: tb/test_mloop_branch_ctrl.sv
`timescale 1ns/1ps
module test_mloop_branch_ctrl;
    localparam int LC_W = 8;
    localparam int EC_W = 4;
    localparam int NS   = 3;
    localparam int RW   = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_wr_en = 1'b0;
    logic [LC_W-1:0] lc_wr_data = '0;
    logic [EC_W-1:0] ec_wr_data = '0;
    logic br_req = 1'b0;
    logic br_taken, br_fall, rot_pulse;
    logic [NS-1:0] stage_pred;
    logic [LC_W-1:0] lc_q;
    logic [EC_W-1:0] ec_q;
    logic [RW-1:0] rot_base;

    always #2.5 clk = ~clk;

    mloop_branch_ctrl #(.LC_W(LC_W), .EC_W(EC_W), .N_STAGES(NS), .ROT_W(RW)) i_mloop_branch_ctrl (
        .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .lc_wr_data(lc_wr_data),
        .ec_wr_data(ec_wr_data), .br_req(br_req), .br_taken(br_taken), .br_fall(br_fall),
        .rot_pulse(rot_pulse), .stage_pred(stage_pred), .lc_q(lc_q), .ec_q(ec_q),
        .rot_base(rot_base)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Arithmetic model state
    int m_lc = 0, m_ec = 0, m_rb = 0, m_taken_cnt = 0;
    logic [NS-1:0] m_pred = '0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample 1 ns after the rising edge
    task automatic step(input string ctx, input bit req, input bit wr, input int lcd, input int ecd);
        int e_tk, e_fl;
        @(negedge clk);
        br_req = req; cnt_wr_en = wr;
        lc_wr_data = LC_W'(lcd); ec_wr_data = EC_W'(ecd);
        e_tk = 0; e_fl = 0;
        if (wr) begin
            m_lc = lcd; m_ec = ecd;
        end else if (req) begin
            if (m_lc != 0) begin
                m_lc--; m_pred = {m_pred[NS-2:0], 1'b1}; e_tk = 1;
            end else if (m_ec != 0) begin
                m_ec--; m_pred = {m_pred[NS-2:0], 1'b0}; e_tk = 1;
            end else begin
                e_fl = 1;
            end
        end
        if (e_tk != 0) begin
            m_rb = (m_rb + (1 << RW) - 1) % (1 << RW);
            m_taken_cnt++;
        end
        @(posedge clk);
        #1;
        chk({ctx, " R6 taken"},  int'(br_taken), e_tk);
        chk({ctx, " R6 rotate"}, int'(rot_pulse), e_tk);
        chk({ctx, " R4 fall"},   int'(br_fall), e_fl);
        chk({ctx, " R5 preds"},  int'(stage_pred), int'(m_pred));
        chk({ctx, " R2 loop count"}, int'(lc_q), m_lc);
        chk({ctx, " R3 drain count"}, int'(ec_q), m_ec);
        chk({ctx, " R6 base"},   int'(rot_base), m_rb);
    endtask

    initial begin
        int rb0, tk0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 loop count", int'(lc_q), 0);
        chk("R1 drain count", int'(ec_q), 0);
        chk("R1 preds", int'(stage_pred), 0);
        chk("R1 base", int'(rot_base), 0);
        chk("R1 pulses", int'({br_taken, br_fall, rot_pulse}), 0);
        @(negedge clk);
        rst = 1'b0;

        // R8 quiet cycles
        for (int i = 0; i < 3; i++) step("R8 idle", 1'b0, 1'b0, 0, 0);

        // R2 R3 R9 sweep of start counts, some runs with idle gaps
        for (int l = 0; l <= 5; l++) begin
            for (int e = 0; e <= 4; e++) begin
                step("R7 load", 1'b0, 1'b1, l, e);
                tk0 = m_taken_cnt;
                for (int k = 0; k <= l + e; k++) begin
                    step("R2/R3 sweep", 1'b1, 1'b0, 0, 0);
                    if (((l + e) % 2) == 1) step("R8 gap", 1'b0, 1'b0, 0, 0);
                end
                chk("R9 taken total", m_taken_cnt - tk0, l + e);
                chk("R9 ended at zero", int'(lc_q) + int'(ec_q), 0);
                step("R4 repeat exit", 1'b1, 1'b0, 0, 0);
            end
        end

        // R7 write beats a simultaneous request
        step("R7 load", 1'b0, 1'b1, 3, 2);
        step("R7 write+req", 1'b1, 1'b1, 6, 1);
        chk("R7 loaded loop count", int'(lc_q), 6);
        chk("R7 loaded drain count", int'(ec_q), 1);
        chk("R7 no taken", int'(br_taken), 0);
        for (int k = 0; k < 8; k++) step("R7 follow", 1'b1, 1'b0, 0, 0);

        // R9 three-stage, five-element loop
        step("R9 load", 1'b0, 1'b1, 4, 3);
        rb0 = int'(rot_base);
        tk0 = m_taken_cnt;
        for (int k = 0; k < 8; k++) step("R9 run", 1'b1, 1'b0, 0, 0);
        chk("R9 base moved by 7", (rb0 - int'(rot_base) + (1 << RW)) % (1 << RW), 7);
        chk("R9 seven taken", m_taken_cnt - tk0, 7);
        chk("R4 final fall", int'(br_fall), 1);

        // R2 largest loop count
        step("R2 max load", 1'b0, 1'b1, (1 << LC_W) - 1, 1);
        for (int k = 0; k < (1 << LC_W) + 1; k++) step("R2 max run", 1'b1, 1'b0, 0, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule